// File: doc/BRIEF.md
# Windowed Register File with Call/Return Traps

This block holds the general-purpose registers of a RISC core as a ring of overlapping windows. Each window gives a procedure 32 register numbers. Eight of them are globals shared by every window. Eight are outputs, eight are locals and eight are inputs. A call steps the current window pointer forward by one and a return steps it back. The outputs of a caller are the same physical entries as the inputs of its callee, so arguments and results cross a call without any copy.

A saved-window pointer marks the oldest window still held in the file. A call that would move onto that window raises an overflow trap. A return into a window that has been spilled raises an underflow trap. In both cases the window pointer waits for the trap handler. The handler moves the data to or from memory and then pulses a done input. The block advances both pointers on that pulse. The block has two combinational read ports and one write port. A write is forwarded to any read of the same entry in the same cycle.

Top module: `rwin_file`

## Requirements
- R1: After reset the current and saved window pointers are both 0, neither trap output is high, and every register reads 0.
- R2: Register numbers 0–7 are globals, 8–15 are outputs, 16–23 are locals and 24–31 are inputs. A global reads the same value from every window.
- R3: Output register 8+k of window w is the same storage as input register 24+k of window (w+1) mod 8.
- R4: The locals of a window are private to it. A write in one window does not change the locals of any other window.
- R5: With no trap pending, a call where (cwp+1) mod 8 differs from the saved pointer sets cwp to (cwp+1) mod 8 on the next edge. A return where cwp differs from the saved pointer sets cwp to (cwp−1) mod 8 on the next edge.
- R6: A call where (cwp+1) mod 8 equals the saved pointer leaves cwp unchanged and raises the overflow output from the next edge. The output stays high until spill-done. Calls and returns are ignored while the trap is pending.
- R7: Spill-done while overflow is pending increments the saved pointer and cwp by one on the same edge and drops the overflow output.
- R8: A return where cwp equals the saved pointer leaves cwp unchanged and raises the underflow output. Fill-done then decrements the saved pointer and cwp by one and drops the output.
- R9: A write lands on the clock edge, at the entry mapped through the cwp of that cycle. A read of the same entry in the same cycle returns the write data on both read ports.
- R10: When call and return are both high in the same cycle, the call takes effect and the return is dropped.
- R11: Spill-done or fill-done without a matching pending trap has no effect on either pointer or on either trap output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call: advance window |
| ret_i | input | 1 | Procedure return: retreat window |
| spill_done_i | input | 1 | Handler finished saving the oldest window |
| fill_done_i | input | 1 | Handler finished restoring the previous window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write register number |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Read port A register number |
| raddr_b_i | input | 5 | Read port B register number |
| rdata_a_o | output | 32 | Read port A data |
| rdata_b_o | output | 32 | Read port B data |
| ovf_trap_o | output | 1 | Overflow trap pending |
| unf_trap_o | output | 1 | Underflow trap pending |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved-window pointer |

## Verification
A wrong window pointer shows on cwp_o one edge after the call or return that caused it. It also changes which physical entry every windowed read reaches, so data written in a window comes back wrong when that window is read again. A mis-aliased output/input pair shows on the first read of an input after a call. A saved pointer that drifts shows as a trap one call too early or too late, and the trap outputs rise on the edge that follows the triggering call or return. Running a full eight-deep call chain and then unwinding it touches every window region.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    typedef enum logic [1:0] {
        WIN_RUN   = 2'd0,
        WIN_SPILL = 2'd1,
        WIN_FILL  = 2'd2
    } win_state_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map #(
    parameter int NWIN = 8,
    parameter int RPR  = 8,
    localparam int RW    = $clog2(RPR),
    localparam int AW    = RW + 2,
    localparam int CW    = $clog2(NWIN),
    localparam int WSPAN = 2 * RPR,
    localparam int PHYS  = RPR + NWIN * WSPAN,
    localparam int PW    = $clog2(PHYS)
) (
    input  logic [AW-1:0] areg_i,
    input  logic [CW-1:0] cwp_i,
    output logic [PW-1:0] phys_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [RW-1:0] idx;
    logic [CW-1:0] win_next;

    always_comb begin
        idx      = areg_i[RW-1:0];
        win_next = cwp_i + ONE;
        case (areg_i[AW-1:RW])
            2'd0:    phys_o = PW'(idx);
            2'd1:    phys_o = PW'(RPR) + PW'(win_next) * PW'(WSPAN) + PW'(RPR) + PW'(idx);
            2'd2:    phys_o = PW'(RPR) + PW'(cwp_i) * PW'(WSPAN) + PW'(idx);
            default: phys_o = PW'(RPR) + PW'(cwp_i) * PW'(WSPAN) + PW'(RPR) + PW'(idx);
        endcase
    end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_done_i,
    input  logic          fill_done_i,
    output logic [CW-1:0] cwp_o,
    output logic [CW-1:0] swp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        win_state_e    st;
        logic [CW-1:0] cwp;
        logic [CW-1:0] swp;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;
    logic [CW-1:0] cwp_inc, cwp_dec;

    always_comb begin
        cwp_inc = cur_q.cwp + ONE;
        cwp_dec = cur_q.cwp - ONE;
        nxt_d   = cur_q;
        case (cur_q.st)
            WIN_RUN: begin
                if (call_i) begin
                    if (cwp_inc == cur_q.swp) nxt_d.st  = WIN_SPILL;
                    else                      nxt_d.cwp = cwp_inc;
                end else if (ret_i) begin
                    if (cur_q.cwp == cur_q.swp) nxt_d.st  = WIN_FILL;
                    else                        nxt_d.cwp = cwp_dec;
                end
            end
            WIN_SPILL: begin
                if (spill_done_i) begin
                    nxt_d.swp = cur_q.swp + ONE;
                    nxt_d.cwp = cwp_inc;
                    nxt_d.st  = WIN_RUN;
                end
            end
            WIN_FILL: begin
                if (fill_done_i) begin
                    nxt_d.swp = cur_q.swp - ONE;
                    nxt_d.cwp = cwp_dec;
                    nxt_d.st  = WIN_RUN;
                end
            end
            default: nxt_d.st = WIN_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= WIN_RUN;
            cur_q.cwp <= '0;
            cur_q.swp <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cwp_o = cur_q.cwp;
    assign swp_o = cur_q.swp;
    assign ovf_o = (cur_q.st == WIN_SPILL);
    assign unf_o = (cur_q.st == WIN_FILL);

    AST_CWP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_o != $past(cwp_o)) |-> ((cwp_o == $past(cwp_o) + ONE) || (cwp_o == $past(cwp_o) - ONE))); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && !unf_o && call_i && (cwp_o + ONE == swp_o)) |=> (ovf_o && $stable(cwp_o))); // R6
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !spill_done_i) |=> ($stable(cwp_o) && $stable(swp_o) && ovf_o)); // R6
    AST_SPILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && spill_done_i) |=> ((swp_o == $past(swp_o) + ONE) && !ovf_o)); // R7
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && fill_done_i) |=> ((swp_o == $past(swp_o) - ONE) && (cwp_o == swp_o) && !unf_o)); // R8
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int DW   = 32,
    parameter int PHYS = 136,
    localparam int PW  = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [PW-1:0] wphys_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [PW-1:0] rphys_a_i,
    input  logic [PW-1:0] rphys_b_i,
    output logic [DW-1:0] rdata_a_o,
    output logic [DW-1:0] rdata_b_o
);
    logic [DW-1:0] mem_q [PHYS];
    logic [DW-1:0] mem_d [PHYS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[wphys_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rdata_a_o = (we_i && (wphys_i == rphys_a_i)) ? wdata_i : mem_q[rphys_a_i];
        rdata_b_o = (we_i && (wphys_i == rphys_b_i)) ? wdata_i : mem_q[rphys_b_i];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(wphys_i)] == $past(wdata_i))); // R9
endmodule

// File: rtl/rwin_file.sv
module rwin_file
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int RPR  = 8,
    parameter int DW   = 32,
    localparam int RW    = $clog2(RPR),
    localparam int AW    = RW + 2,
    localparam int CW    = $clog2(NWIN),
    localparam int PHYS  = RPR + NWIN * 2 * RPR,
    localparam int PW    = $clog2(PHYS),
    localparam int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_done_i,
    input  logic          fill_done_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_a_o,
    output logic [DW-1:0] rdata_b_o,
    output logic          ovf_trap_o,
    output logic          unf_trap_o,
    output logic [CW-1:0] cwp_o,
    output logic [CW-1:0] swp_o
);
    logic [AW-1:0] areg [NPORT];
    logic [PW-1:0] phys [NPORT];

    assign areg[0] = waddr_i;
    assign areg[1] = raddr_a_i;
    assign areg[2] = raddr_b_i;

    rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_i(call_i), .ret_i(ret_i),
        .spill_done_i(spill_done_i), .fill_done_i(fill_done_i),
        .cwp_o(cwp_o), .swp_o(swp_o),
        .ovf_o(ovf_trap_o), .unf_o(unf_trap_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NWIN(NWIN), .RPR(RPR)) u_map (
            .areg_i(areg[p]),
            .cwp_i(cwp_o),
            .phys_o(phys[p])
        );
    end

    rwin_store #(.DW(DW), .PHYS(PHYS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(we_i), .wphys_i(phys[0]), .wdata_i(wdata_i),
        .rphys_a_i(phys[1]), .rphys_b_i(phys[2]),
        .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o)
    );

    AST_GLOBAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a_i[AW-1:RW] == 2'd0) |-> (phys[1] == PW'(raddr_a_i))); // R2
    AST_WINDOW_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a_i[AW-1:RW] == 2'd1 && raddr_b_i[AW-1:RW] == 2'd3 && raddr_a_i[RW-1:0] == raddr_b_i[RW-1:0])
        |-> (phys[1] != phys[2])); // R3
    AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap_o, unf_trap_o})); // R6
endmodule

// File: tb/sim_rwin_file.sv
`timescale 1ns/1ps
module sim_rwin_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, spill_done_i = 1'b0, fill_done_i = 1'b0;
    logic        we_i = 1'b0;
    logic [4:0]  waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_a_o, rdata_b_o;
    logic        ovf_trap_o, unf_trap_o;
    logic [2:0]  cwp_o, swp_o;

    int checks = 0;
    int errors = 0;
    int cwp_m = 0;
    int swp_m = 0;
    logic [31:0] exp_mem [136];

    always #2.5 clk = ~clk;

    rwin_file u0 (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_done_i(spill_done_i), .fill_done_i(fill_done_i),
        .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
        .raddr_a_i(raddr_a_i), .raddr_b_i(raddr_b_i),
        .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o),
        .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
        .cwp_o(cwp_o), .swp_o(swp_o)
    );

    function automatic int phys_of(int a, int w);
        int r = a % 8;
        case (a / 8)
            0:       return r;
            1:       return 8 + ((w + 1) % 8) * 16 + 8 + r;
            2:       return 8 + w * 16 + r;
            default: return 8 + w * 16 + 8 + r;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ptr(string tag, int ovf, int unf);
        chk(tag, {29'd0, cwp_o}, cwp_m);
        chk(tag, {29'd0, swp_o}, swp_m);
        chk(tag, {31'd0, ovf_trap_o}, ovf);
        chk(tag, {31'd0, unf_trap_o}, unf);
    endtask

    task automatic wr(int a, logic [31:0] d);
        we_i = 1'b1; waddr_i = a[4:0]; wdata_i = d;
        tick();
        we_i = 1'b0;
        exp_mem[phys_of(a, cwp_m)] = d;
    endtask

    task automatic rd(string tag, int a);
        raddr_a_i = a[4:0]; raddr_b_i = a[4:0];
        #0.2;
        chk(tag, rdata_a_o, exp_mem[phys_of(a, cwp_m)]);
        chk(tag, rdata_b_o, exp_mem[phys_of(a, cwp_m)]);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick();
        sig = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 136; i++) exp_mem[i] = '0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_ptr("R1", 0, 0);
        for (int a = 0; a < 32; a++) rd("R1", a);

        // R2 globals written once
        for (int i = 0; i < 8; i++) wr(i, 32'hA000_0000 + i);

        // R3 R5 call chain through seven windows
        for (int w = 0; w < 7; w++) begin
            for (int i = 0; i < 8; i++) wr(16 + i, 32'h1000_0000 + w * 16 + i);
            for (int i = 0; i < 8; i++) wr(8 + i, 32'hB000_0000 + w * 16 + i);
            pulse(call_i);
            cwp_m = w + 1;
            chk_ptr("R5", 0, 0);
            for (int i = 0; i < 8; i++)
                chk_in(w, i);
            for (int i = 0; i < 8; i++) rd("R2", i);
        end

        // R6 overflow at window 7
        for (int i = 0; i < 8; i++) wr(16 + i, 32'h1000_0070 + i);
        pulse(call_i);
        chk_ptr("R6", 1, 0);
        pulse(ret_i);
        chk_ptr("R6", 1, 0);
        pulse(call_i);
        chk_ptr("R6", 1, 0);
        pulse(fill_done_i);
        chk_ptr("R11", 1, 0);
        pulse(spill_done_i);
        cwp_m = 0; swp_m = 1;
        chk_ptr("R7", 0, 0);
        for (int i = 0; i < 8; i++) rd("R2", i);
        pulse(spill_done_i);
        chk_ptr("R11", 0, 0);
        pulse(fill_done_i);
        chk_ptr("R11", 0, 0);
        for (int i = 0; i < 8; i++) wr(16 + i, 32'h2000_0000 + i);

        // R4 R5 unwind back to window 1
        for (int k = 0; k < 7; k++) begin
            pulse(ret_i);
            cwp_m = (cwp_m + 7) % 8;
            chk_ptr("R5", 0, 0);
            for (int i = 0; i < 8; i++) rd("R4", 16 + i);
        end

        // R8 underflow at window 1
        pulse(ret_i);
        chk_ptr("R8", 0, 1);
        pulse(call_i);
        chk_ptr("R8", 0, 1);
        pulse(spill_done_i);
        chk_ptr("R11", 0, 1);
        pulse(fill_done_i);
        cwp_m = 0; swp_m = 0;
        chk_ptr("R8", 0, 0);
        for (int i = 0; i < 8; i++) rd("R4", 16 + i);

        // R10 call and return together
        call_i = 1'b1; ret_i = 1'b1;
        tick();
        call_i = 1'b0; ret_i = 1'b0;
        cwp_m = 1;
        chk_ptr("R10", 0, 0);

        // R9 forwarding to both ports
        we_i = 1'b1; waddr_i = 5'd16; wdata_i = 32'hC0DE_0016;
        raddr_a_i = 5'd16; raddr_b_i = 5'd16;
        #0.5;
        chk("R9", rdata_a_o, 32'hC0DE_0016);
        chk("R9", rdata_b_o, 32'hC0DE_0016);
        tick();
        we_i = 1'b0;
        exp_mem[phys_of(16, cwp_m)] = 32'hC0DE_0016;
        rd("R9", 16);

        // R9 write in the same cycle as a call uses the old window
        we_i = 1'b1; waddr_i = 5'd17; wdata_i = 32'hD00D_0017; call_i = 1'b1;
        tick();
        we_i = 1'b0; call_i = 1'b0;
        exp_mem[phys_of(17, 1)] = 32'hD00D_0017;
        cwp_m = 2;
        chk_ptr("R5", 0, 0);
        rd("R4", 17);
        pulse(ret_i);
        cwp_m = 1;
        rd("R9", 17);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk_in(int w, int i);
        raddr_a_i = 5'(24 + i); raddr_b_i = 5'(24 + i);
        #0.2;
        chk("R3", rdata_a_o, 32'hB000_0000 + w * 16 + i);
        chk("R3", rdata_b_o, exp_mem[phys_of(24 + i, cwp_m)]);
    endtask
endmodule